// File: doc/BRIEF.md
# Two-Level Page Walker with 4 MB Pages

This block translates a 32-bit virtual address to a physical address of up to 40 bits. It walks a two-level tree of 32-bit entries held in memory: first a directory, then a table. Each request carries the virtual address, the access kind (read, write or fetch), a user/supervisor flag, the root pointer and a large-page enable. The walker reads the entries it needs through a valid/ready request channel and a separate response channel. It writes status bits back through the same request channel.

When it reaches the leaf entry, the walker shows the combined user and read/write attributes to an external permission checker. It then waits for the checker's verdict. The walk ends with one `done_valid` cycle. That cycle carries either a translation (physical address, page size and attributes) or a fault code together with the faulting virtual address.

A directory entry can map a 4 MB page directly. In that case the entry also supplies the physical address bits above bit 31.

Top module: `pgwalk32`

## Requirements
- R1: The directory entry is read from the word address formed by root bits 31:12, then virtual address bits 31:22, then two zero bits.
- R2: On the 4 KB path, the table entry is read from the address formed by directory entry bits 31:12, then virtual address bits 21:12, then two zero bits.
- R3: If an entry fetched has its present bit (bit 0) clear, the walk ends with fault code 1 and no further memory access.
- R4: If the directory entry has its page-size bit (bit 7) set and the large-page enable was high at request time, no table entry is read and the result is a 4 MB page (`done_large` = 1). If the enable was low, that bit is ignored and the 4 KB path is taken.
- R5: For a 4 MB page, physical bits 39:32 come from entry bits 20:13 and bits 31:22 come from entry bits 31:22. If entry bit 21 is set, the walk ends with fault code 2.
- R6: On the 4 KB path, a directory entry whose accessed bit (bit 5) is clear is written back with that bit set before the table entry is read. A directory entry whose accessed bit is already set is not written.
- R7: When the checker allows the access, the leaf entry is written back with its accessed bit set. If the access kind is write (kind code 1) and the dirty bit (bit 6) was clear, the dirty bit is set too. Reads (code 0) and fetches (code 2) leave the dirty bit unchanged.
- R8: The reported user attribute (entry bit 2) and read/write attribute (entry bit 1) are the AND of the directory and table entries on the 4 KB path, and the directory entry's own bits on the 4 MB path.
- R9: A 4 KB result is zero in bits 39:32, table entry bits 31:12 in bits 31:12, and virtual address bits 11:0 below them.
- R10: When the leaf needs no write-back, `done_valid` is high in the cycle after the final read response.
- R11: When the checker's allow input is low, the walk ends with fault code 3, no leaf write, and `done_va` equal to the requested virtual address.
- R12: After reset the walker is idle and ready. A memory request held without `mem_ready` keeps its address and direction stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access from user level |
| req_root | input | 32 | Directory base pointer |
| req_big_en | input | 1 | Allow 4 MB pages |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory request accepted |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response data |
| chk_valid | output | 1 | Attributes presented to checker |
| chk_user_attr | output | 1 | Combined user attribute |
| chk_rw_attr | output | 1 | Combined read/write attribute |
| chk_kind | output | 2 | Access kind of the walk |
| chk_priv_user | output | 1 | User flag of the walk |
| chk_allow | input | 1 | Checker verdict while chk_valid |
| done_valid | output | 1 | Result valid for one cycle |
| done_code | output | 2 | 0 ok, 1 not present, 2 reserved, 3 denied |
| done_pa | output | 40 | Physical address |
| done_large | output | 1 | Result is a 4 MB page |
| done_user_attr | output | 1 | Combined user attribute |
| done_rw_attr | output | 1 | Combined read/write attribute |
| done_va | output | 32 | Virtual address of the walk |

## Verification
The assertions rely on three conditions. The memory sends exactly one response for each accepted read. It sends no response while no read is outstanding. The checker's verdict stays stable during the check cycle. The bench's memory model meets all three by construction. It holds at most one pending read, returns it after a random delay of zero to two cycles, and inserts random ready stalls. The verdict is chosen once per walk and held until the walk ends.

// File: rtl/pgwalk32.sv
module pgwalk32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [1:0]  req_kind,
  input  logic        req_user,
  input  logic [31:0] req_root,
  input  logic        req_big_en,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  output logic        chk_valid,
  output logic        chk_user_attr,
  output logic        chk_rw_attr,
  output logic [1:0]  chk_kind,
  output logic        chk_priv_user,
  input  logic        chk_allow,
  output logic        done_valid,
  output logic [1:0]  done_code,
  output logic [39:0] done_pa,
  output logic        done_large,
  output logic        done_user_attr,
  output logic        done_rw_attr,
  output logic [31:0] done_va
);
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;
  localparam int B_RSV = 21;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] F_NONE = 2'd0, F_NP = 2'd1, F_RSV = 2'd2, F_DENY = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RDIR, S_WDIR, S_ADIR, S_RTBL, S_WTBL, S_CHK, S_WBL, S_FIN
  } st_t;

  st_t         st;
  logic [31:0] va_q, root_q, dir_q, leaf_q;
  logic [1:0]  kind_q, fault_q;
  logic        user_q, big_q, large_q;

  logic [31:0] dir_addr, tbl_addr;
  logic        need_wb;

  assign dir_addr = {root_q[31:12], va_q[31:22], 2'b00};
  assign tbl_addr = {dir_q[31:12], va_q[21:12], 2'b00};
  assign need_wb  = !leaf_q[B_A] || (kind_q == K_WRITE && !leaf_q[B_D]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      dir_q   <= '0;
      leaf_q  <= '0;
      kind_q  <= '0;
      fault_q <= F_NONE;
      user_q  <= 1'b0;
      big_q   <= 1'b0;
      large_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          root_q  <= req_root;
          kind_q  <= req_kind;
          user_q  <= req_user;
          big_q   <= req_big_en;
          large_q <= 1'b0;
          fault_q <= F_NONE;
          st      <= S_RDIR;
        end
        S_RDIR: if (mem_ready) st <= S_WDIR;
        S_WDIR: if (rsp_valid) begin
          dir_q <= rsp_data;
          if (!rsp_data[B_P]) begin
            fault_q <= F_NP;
            st      <= S_FIN;
          end else if (rsp_data[B_PS] && big_q) begin
            large_q <= 1'b1;
            leaf_q  <= rsp_data;
            if (rsp_data[B_RSV]) begin
              fault_q <= F_RSV;
              st      <= S_FIN;
            end else begin
              st <= S_CHK;
            end
          end else if (!rsp_data[B_A]) begin
            st <= S_ADIR;
          end else begin
            st <= S_RTBL;
          end
        end
        S_ADIR: if (mem_ready) begin
          dir_q[B_A] <= 1'b1;
          st <= S_RTBL;
        end
        S_RTBL: if (mem_ready) st <= S_WTBL;
        S_WTBL: if (rsp_valid) begin
          leaf_q <= rsp_data;
          if (!rsp_data[B_P]) begin
            fault_q <= F_NP;
            st      <= S_FIN;
          end else begin
            st <= S_CHK;
          end
        end
        S_CHK: st <= (chk_allow && need_wb) ? S_WBL : S_IDLE;
        S_WBL: if (mem_ready) begin
          fault_q <= F_NONE;
          st      <= S_FIN;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_RDIR) || (st == S_ADIR) || (st == S_RTBL) || (st == S_WBL);
  assign mem_we    = (st == S_ADIR) || (st == S_WBL);
  assign mem_addr  = (st == S_RTBL) ? tbl_addr :
                     (st == S_WBL && !large_q) ? tbl_addr : dir_addr;
  assign mem_wdata = (st == S_ADIR) ? (dir_q | (32'h1 << B_A)) :
                     (leaf_q | (32'h1 << B_A) | ((kind_q == K_WRITE) ? (32'h1 << B_D) : 32'h0));

  assign chk_valid      = (st == S_CHK);
  assign chk_user_attr  = done_user_attr;
  assign chk_rw_attr    = done_rw_attr;
  assign chk_kind       = kind_q;
  assign chk_priv_user  = user_q;

  assign done_valid     = (st == S_FIN) || (st == S_CHK && !(chk_allow && need_wb));
  assign done_code      = (st == S_FIN) ? fault_q : (chk_allow ? F_NONE : F_DENY);
  assign done_large     = large_q;
  assign done_user_attr = large_q ? dir_q[B_US] : (dir_q[B_US] & leaf_q[B_US]);
  assign done_rw_attr   = large_q ? dir_q[B_RW] : (dir_q[B_RW] & leaf_q[B_RW]);
  assign done_pa        = large_q ? {leaf_q[20:13], leaf_q[31:22], va_q[21:0]}
                                  : {8'h00, leaf_q[31:12], va_q[11:0]};
  assign done_va        = va_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[B_A]); // R7
  AST_DIRTY_ON_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WBL) && (kind_q != K_WRITE) |-> mem_wdata[B_D] == leaf_q[B_D]); // R7
  AST_RSV_ONLY_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_code == F_RSV |-> done_large); // R5
  AST_NP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN) && (fault_q == F_NP) |-> $past(st) != S_WBL); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !mem_valid); // R10
  AST_DENY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_allow |=> !mem_valid); // R11
endmodule

// File: tb/pgwalk32_test.sv
module pgwalk32_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [31:0] req_root = '0;
  logic        req_big_en = 1'b0;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        chk_valid, chk_user_attr, chk_rw_attr, chk_priv_user;
  logic [1:0]  chk_kind;
  logic        chk_allow = 1'b1;
  logic        done_valid;
  logic [1:0]  done_code;
  logic [39:0] done_pa;
  logic        done_large, done_user_attr, done_rw_attr;
  logic [31:0] done_va;

  always #(PERIOD/2) clk = ~clk;

  pgwalk32 uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_kind(req_kind),
    .req_user(req_user), .req_root(req_root), .req_big_en(req_big_en),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .chk_valid(chk_valid), .chk_user_attr(chk_user_attr), .chk_rw_attr(chk_rw_attr),
    .chk_kind(chk_kind), .chk_priv_user(chk_priv_user), .chk_allow(chk_allow),
    .done_valid(done_valid), .done_code(done_code), .done_pa(done_pa),
    .done_large(done_large), .done_user_attr(done_user_attr), .done_rw_attr(done_rw_attr),
    .done_va(done_va)
  );

  logic [31:0] mem  [logic [31:0]];
  logic [31:0] emem [logic [31:0]];
  int nchecks = 0, nerr = 0;
  int nwrites = 0;
  int pcyc = 0, last_rsp = 0;
  bit pend = 0;
  int pend_dly = 0;
  logic [31:0] pend_addr = '0;
  bit hung = 0;

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] erd(logic [31:0] a);
    return emem.exists(a) ? emem[a] : 32'h0;
  endfunction

  always @(posedge clk) pcyc++;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mrd(pend_addr);
        pend      = 0;
        last_rsp  = pcyc;
      end else pend_dly--;
    end
    mem_ready = 1'b0;
    if (rst_n && mem_valid && ($urandom % 4 != 0)) begin
      mem_ready = 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        nwrites++;
      end else begin
        pend = 1;
        pend_addr = mem_addr;
        pend_dly = $urandom % 3;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] va, root, input logic [1:0] kind, input logic big, allow,
                       output logic [1:0] code, output logic [39:0] pa, output logic lg, us, rw,
                       output int nwr, output logic [31:0] da, ta, output logic tail_wb);
    logic [31:0] d, t, la;
    code = 0; pa = '0; lg = 0; us = 0; rw = 0; nwr = 0; tail_wb = 0;
    da = {root[31:12], va[31:22], 2'b00};
    d = erd(da);
    ta = {d[31:12], va[21:12], 2'b00};
    if (!d[0]) begin code = 1; return; end
    if (d[7] && big) begin
      if (d[21]) begin code = 2; lg = 1; return; end
      lg = 1; us = d[2]; rw = d[1];
      pa = {d[20:13], d[31:22], va[21:0]};
      t = d; la = da;
    end else begin
      if (!d[5]) begin d[5] = 1'b1; emem[da] = d; nwr++; end
      t = erd(ta);
      if (!t[0]) begin code = 1; return; end
      us = d[2] & t[2]; rw = d[1] & t[1];
      pa = {8'h00, t[31:12], va[11:0]};
      la = ta;
    end
    if (!allow) begin code = 3; return; end
    if (!t[5] || (kind == 2'd1 && !t[6])) begin
      t[5] = 1'b1;
      if (kind == 2'd1) t[6] = 1'b1;
      emem[la] = t;
      nwr++;
      tail_wb = 1;
    end
  endtask

  task automatic walk(input logic [31:0] va, root, input logic [1:0] kind, input logic big, allow);
    logic [1:0] ecode; logic [39:0] epa; logic elg, eus, erw, ewb;
    logic [31:0] da, ta;
    int enw, w0, n;
    if (hung) return;
    emem = mem;
    model(va, root, kind, big, allow, ecode, epa, elg, eus, erw, enw, da, ta, ewb);
    w0 = nwrites;
    @(negedge clk);
    req_va = va; req_root = root; req_kind = kind; req_big_en = big;
    req_user = va[0]; chk_allow = allow; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done_valid && n < 500) begin @(negedge clk); n++; end
    if (!done_valid) begin
      nchecks++; nerr++; hung = 1;
      $display("FAIL watchdog R12 actual=hung expected=done");
      return;
    end
    chk("R1 R2 R3 R5 R11 fault code", done_code, ecode);
    if (ecode == 0) begin
      chk("R4 page size", done_large, elg);
      chk(elg ? "R5 large physical address" : "R9 small physical address", done_pa, epa);
      chk("R8 user attribute", done_user_attr, eus);
      chk("R8 rw attribute", done_rw_attr, erw);
      if (!ewb) chk("R10 latency after final response", pcyc - last_rsp, 1);
    end else begin
      chk("R11 fault address", done_va, va);
    end
    @(negedge clk);
    chk("R6 R7 R3 write count", nwrites - w0, enw);
    chk("R6 directory word", mrd(da), erd(da));
    chk("R7 leaf word", mrd(ta), erd(ta));
  endtask

  task automatic setup(input logic [31:0] va, root, dword, tword);
    logic [31:0] da;
    mem.delete();
    da = {root[31:12], va[31:22], 2'b00};
    mem[da] = dword;
    if ({dword[31:12], va[21:12], 2'b00} != da) mem[{dword[31:12], va[21:12], 2'b00}] = tword;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 reset ready", req_ready, 1);
    chk("R12 reset no memory request", mem_valid, 0);
    chk("R12 reset no result", done_valid, 0);
    rst_n = 1'b1;

    // R3: directory not present
    setup(32'h1234_5678, 32'h0010_0000, 32'h0000_0066, 32'h0);
    walk(32'h1234_5678, 32'h0010_0000, 2'd0, 1'b1, 1'b1);
    // R3: table not present
    setup(32'h0040_1000, 32'h0020_0000, 32'h0030_0027, 32'h0000_0006);
    walk(32'h0040_1000, 32'h0020_0000, 2'd0, 1'b0, 1'b1);
    // R5: reserved bit in a large directory entry
    setup(32'h8000_0abc, 32'h0001_0000, 32'h0020_00a7, 32'h0);
    walk(32'h8000_0abc, 32'h0001_0000, 2'd0, 1'b1, 1'b1);
    // R4 R5: large page with high address bits, write sets dirty
    setup(32'hc03f_fffc, 32'h0003_0000, 32'hffdf_e087, 32'h0);
    walk(32'hc03f_fffc, 32'h0003_0000, 2'd1, 1'b1, 1'b1);
    // R4: size bit ignored when large pages disabled, R6 directory A set
    setup(32'h0123_4567, 32'h0004_0000, 32'h0050_0087, 32'hABCD_E067);
    walk(32'h0123_4567, 32'h0004_0000, 2'd2, 1'b0, 1'b1);
    // R7: write to clean leaf
    setup(32'h0000_2345, 32'h0006_0000, 32'h0070_0027, 32'h1234_5007);
    walk(32'h0000_2345, 32'h0006_0000, 2'd1, 1'b0, 1'b1);
    // R10: leaf already accessed, read needs no write-back
    setup(32'h0000_2345, 32'h0006_0000, 32'h0070_0027, 32'h1234_5027);
    walk(32'h0000_2345, 32'h0006_0000, 2'd0, 1'b0, 1'b1);
    // R11: checker denies, no leaf write
    setup(32'h0000_3fff, 32'h0008_0000, 32'h0090_0027, 32'h0a00_0003);
    walk(32'h0000_3fff, 32'h0008_0000, 2'd1, 1'b0, 1'b0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] va, root, d, t;
      va   = $urandom;
      root = {$urandom, 12'h000} & 32'hFFFF_F000;
      d    = $urandom;
      t    = $urandom;
      d[0] = ($urandom % 8 != 0);
      t[0] = ($urandom % 8 != 0);
      d[21] = ($urandom % 5 == 0);
      setup(va, root, d, t);
      walk(va, root, 2'($urandom % 3), 1'($urandom), ($urandom % 4 != 0));
    end

    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule